// File: doc/BRIEF.md
# DRAM Channel Select Decoder

The decoder decides which of two DRAM channels serves a system physical address. Every address that arrives with an input-valid pulse is classified by a fixed priority of modes. Ganged operation forces channel 0. An explicit high-range request follows a configured select-high bit. Channel interleaving takes a single address bit, or a hashed bit, or a bit chosen by the node interleave field. A fallback inverts the select-high bit when the high range is enabled and interleaving is off. In every other case the result is channel 0.

The configuration fields are static inputs. Software or a neighbouring block holds them steady while lookups run. The result is registered: one clock after an accepted address, `out_valid` is high for one cycle and `out_chan` carries the channel. The decoder accepts one address on every cycle and has no back-pressure. A consumer must take the result in the cycle it is strobed, because `out_chan` keeps that value only until the next accepted address replaces it.

Top module: `chsel_decoder`

## Requirements
- R1: While `cfg_gang_en` is 1, the channel produced for an accepted address is 0, whatever the other inputs are.
- R2: With ganging off and `hi_range_sel` set to 1, the channel equals `cfg_sel_hi`.
- R3: With ganging off, `hi_range_sel` 0, `cfg_il_en` 1 and `cfg_il_mode` = 2'b00, the channel equals address bit 6.
- R4: Under the same conditions with `cfg_il_mode` = 2'b10 or 2'b11, the channel is the XOR of address bits [20:16]. This value is then XORed with address bit 6 for 2'b10, and with address bit 9 for 2'b11.
- R5: Under the same conditions with `cfg_il_mode` = 2'b01, the channel is chosen by `node_il_en`. If bit 2 is set it is address bit 15. Otherwise, if bit 1 is set, it is bit 14. Otherwise, if bit 0 is set, it is bit 13. If no bit is set it is bit 12.
- R6: With ganging off, `hi_range_sel` 0, `cfg_il_en` 0 and `cfg_hi_range_en` 1, the channel is the inverse of `cfg_sel_hi`.
- R7: With ganging off, `hi_range_sel` 0, `cfg_il_en` 0 and `cfg_hi_range_en` 0, the channel is 0.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. `out_chan` changes only on an accepted address and holds its value otherwise.
- R9: While `rst_n` is low at a rising clock edge, `out_valid` and `out_chan` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Address is presented for lookup this cycle |
| sys_addr | input | 48 | System physical address |
| hi_range_sel | input | 1 | Request that the address be steered as a high-range access |
| node_il_en | input | 3 | Node interleave-enable field |
| cfg_gang_en | input | 1 | Channels operate ganged |
| cfg_sel_hi | input | 1 | Channel used for high-range accesses |
| cfg_il_en | input | 1 | Channel interleaving enabled |
| cfg_hi_range_en | input | 1 | High range is enabled |
| cfg_il_mode | input | 2 | Interleave address mode |
| out_valid | output | 1 | One-cycle strobe for a finished lookup |
| out_chan | output | 1 | Selected channel index |

## Verification
The bench goes after the priority edges where two modes are both enabled. Examples are ganging together with a high-range request, and a high-range request together with interleaving. A design with the wrong priority order returns the lower mode's bit in those cases. The hashed modes are driven with address slices of odd and even weight, with bits 6 and 9 set to different values. A decoder that drops the parity term, or picks the wrong companion bit, then flips the channel. The node field is tested with several bits set at once, so a lowest-first priority is exposed. Idle cycles after a result show whether the strobe is stretched or the channel drifts between lookups.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  typedef enum logic [1:0] {
    IL_FINE    = 2'b00,
    IL_NODE    = 2'b01,
    IL_HASH_LO = 2'b10,
    IL_HASH_HI = 2'b11
  } il_mode_e;

  typedef struct packed {
    logic     gang_en;
    logic     sel_hi;
    logic     il_en;
    logic     hi_range_en;
    il_mode_e il_mode;
  } chsel_cfg_t;

endpackage

// File: rtl/chsel_node_pick.sv
module chsel_node_pick #(
  parameter int ADDR_W   = 48,
  parameter int NODE_W   = 3,
  parameter int BASE_BIT = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NODE_W-1:0] node_il_en,
  output logic              bit_o
);
  localparam int TOP_BIT = BASE_BIT + NODE_W;

  // The highest set field bit wins; an empty field falls back to BASE_BIT.
  always_comb begin
    bit_o = addr[BASE_BIT];
    for (int i = 0; i < NODE_W; i++) begin
      if (node_il_en[i]) bit_o = addr[BASE_BIT + 1 + i];
    end
  end

  if (TOP_BIT >= ADDR_W) begin : g_bad_width
    initial $display("chsel_node_pick: node bits exceed address width");
  end
endmodule

// File: rtl/chsel_intlv.sv
module chsel_intlv
  import chsel_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int NODE_W    = 3,
  parameter int FINE_BIT  = 6,
  parameter int ALT_BIT   = 9,
  parameter int PAR_LO    = 16,
  parameter int PAR_W     = 5,
  parameter int NODE_BASE = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  il_mode_e          mode,
  input  logic [NODE_W-1:0] node_il_en,
  output logic              chan_o
);
  logic par_bit;
  logic node_bit;

  if (PAR_W > 0) begin : g_par
    assign par_bit = ^addr[PAR_LO +: PAR_W];
  end else begin : g_nopar
    assign par_bit = 1'b0;
  end

  chsel_node_pick #(
    .ADDR_W  (ADDR_W),
    .NODE_W  (NODE_W),
    .BASE_BIT(NODE_BASE)
  ) u_node (
    .addr      (addr),
    .node_il_en(node_il_en),
    .bit_o     (node_bit)
  );

  always_comb begin
    unique case (mode)
      IL_FINE:    chan_o = addr[FINE_BIT];
      IL_NODE:    chan_o = node_bit;
      IL_HASH_LO: chan_o = par_bit ^ addr[FINE_BIT];
      IL_HASH_HI: chan_o = par_bit ^ addr[ALT_BIT];
      default:    chan_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/chsel_prio.sv
module chsel_prio
  import chsel_pkg::*;
(
  input  chsel_cfg_t cfg,
  input  logic       hi_range_sel,
  input  logic       il_chan,
  output logic       chan_o
);
  always_comb begin
    if (cfg.gang_en)          chan_o = 1'b0;
    else if (hi_range_sel)    chan_o = cfg.sel_hi;
    else if (cfg.il_en)       chan_o = il_chan;
    else if (cfg.hi_range_en) chan_o = ~cfg.sel_hi;
    else                      chan_o = 1'b0;
  end
endmodule

// File: rtl/chsel_decoder.sv
module chsel_decoder
  import chsel_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int NODE_W    = 3,
  parameter int FINE_BIT  = 6,
  parameter int ALT_BIT   = 9,
  parameter int PAR_LO    = 16,
  parameter int PAR_W     = 5,
  parameter int NODE_BASE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic              hi_range_sel,
  input  logic [NODE_W-1:0] node_il_en,
  input  logic              cfg_gang_en,
  input  logic              cfg_sel_hi,
  input  logic              cfg_il_en,
  input  logic              cfg_hi_range_en,
  input  logic [1:0]        cfg_il_mode,
  output logic              out_valid,
  output logic              out_chan
);
  chsel_cfg_t cfg;
  logic       il_chan;
  logic       chan_d;

  assign cfg.gang_en     = cfg_gang_en;
  assign cfg.sel_hi      = cfg_sel_hi;
  assign cfg.il_en       = cfg_il_en;
  assign cfg.hi_range_en = cfg_hi_range_en;
  assign cfg.il_mode     = il_mode_e'(cfg_il_mode);

  chsel_intlv #(
    .ADDR_W   (ADDR_W),
    .NODE_W   (NODE_W),
    .FINE_BIT (FINE_BIT),
    .ALT_BIT  (ALT_BIT),
    .PAR_LO   (PAR_LO),
    .PAR_W    (PAR_W),
    .NODE_BASE(NODE_BASE)
  ) u_intlv (
    .addr      (sys_addr),
    .mode      (cfg.il_mode),
    .node_il_en(node_il_en),
    .chan_o    (il_chan)
  );

  chsel_prio u_prio (
    .cfg         (cfg),
    .hi_range_sel(hi_range_sel),
    .il_chan     (il_chan),
    .chan_o      (chan_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_chan <= chan_d;
    end
  end
endmodule

// File: rtl/chsel_decoder_chk.sv
module chsel_decoder_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] sys_addr,
  input logic              hi_range_sel,
  input logic              cfg_gang_en,
  input logic              cfg_sel_hi,
  input logic              cfg_il_en,
  input logic              cfg_hi_range_en,
  input logic [1:0]        cfg_il_mode,
  input logic              out_valid,
  input logic              out_chan
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_chan));
  // R1
  gang_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_gang_en) |=> !out_chan);
  // R2
  hi_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_gang_en && hi_range_sel) |=> (out_chan == $past(cfg_sel_hi)));
  // R3
  fine_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_gang_en && !hi_range_sel && cfg_il_en && cfg_il_mode == 2'b00)
      |=> (out_chan == $past(sys_addr[6])));
  // R6
  inv_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_gang_en && !hi_range_sel && !cfg_il_en && cfg_hi_range_en)
      |=> (out_chan == !$past(cfg_sel_hi)));
  // R7
  default_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_gang_en && !hi_range_sel && !cfg_il_en && !cfg_hi_range_en)
      |=> !out_chan);
endmodule

bind chsel_decoder chsel_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .sys_addr       (sys_addr),
  .hi_range_sel   (hi_range_sel),
  .cfg_gang_en    (cfg_gang_en),
  .cfg_sel_hi     (cfg_sel_hi),
  .cfg_il_en      (cfg_il_en),
  .cfg_hi_range_en(cfg_hi_range_en),
  .cfg_il_mode    (cfg_il_mode),
  .out_valid      (out_valid),
  .out_chan       (out_chan)
);

// File: tb/tb_chsel_decoder.sv
`timescale 1ns/1ps
module tb_chsel_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [47:0] sys_addr = '0;
  logic        hi_range_sel = 1'b0;
  logic [2:0]  node_il_en = '0;
  logic        cfg_gang_en = 1'b0;
  logic        cfg_sel_hi = 1'b0;
  logic        cfg_il_en = 1'b0;
  logic        cfg_hi_range_en = 1'b0;
  logic [1:0]  cfg_il_mode = 2'b00;
  logic        out_valid;
  logic        out_chan;

  int vectors = 0;
  int miscompares = 0;
  logic held = 1'b0;

  always #10 clk = ~clk;

  chsel_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
    .hi_range_sel(hi_range_sel), .node_il_en(node_il_en),
    .cfg_gang_en(cfg_gang_en), .cfg_sel_hi(cfg_sel_hi), .cfg_il_en(cfg_il_en),
    .cfg_hi_range_en(cfg_hi_range_en), .cfg_il_mode(cfg_il_mode),
    .out_valid(out_valid), .out_chan(out_chan)
  );

  function automatic logic ref_chan();
    logic p;
    p = ^sys_addr[20:16];
    if (cfg_gang_en) return 1'b0;
    if (hi_range_sel) return cfg_sel_hi;
    if (cfg_il_en) begin
      case (cfg_il_mode)
        2'b00: return sys_addr[6];
        2'b10: return p ^ sys_addr[6];
        2'b11: return p ^ sys_addr[9];
        default: begin
          if (node_il_en[2]) return sys_addr[15];
          if (node_il_en[1]) return sys_addr[14];
          if (node_il_en[0]) return sys_addr[13];
          return sys_addr[12];
        end
      endcase
    end
    if (cfg_hi_range_en) return ~cfg_sel_hi;
    return 1'b0;
  endfunction

  function automatic string ref_req();
    if (cfg_gang_en) return "R1";
    if (hi_range_sel) return "R2";
    if (cfg_il_en) begin
      if (cfg_il_mode == 2'b00) return "R3";
      if (cfg_il_mode == 2'b01) return "R5";
      return "R4";
    end
    if (cfg_hi_range_en) return "R6";
    return "R7";
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive one cycle with the current inputs; check at the next falling edge.
  task automatic cycle(input logic v);
    logic  e;
    string rq;
    in_valid = v;
    e  = ref_chan();
    rq = ref_req();
    @(negedge clk);
    check(out_valid, v, "R8");
    if (v) held = e;
    check(out_chan, held, v ? rq : "R8");
  endtask

  task automatic set_cfg(input logic g, input logic sh, input logic il,
                         input logic hr, input logic [1:0] m);
    cfg_gang_en = g; cfg_sel_hi = sh; cfg_il_en = il;
    cfg_hi_range_en = hr; cfg_il_mode = m;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid, 1'b0, "R9");
    check(out_chan, 1'b0, "R9");
    rst_n = 1'b1;

    // R1: ganging wins over every other setting
    set_cfg(1, 1, 1, 1, 2'b00); hi_range_sel = 1; sys_addr = 48'h40; cycle(1);
    // R2: high-range request wins over interleave
    set_cfg(0, 1, 1, 1, 2'b00); hi_range_sel = 1; sys_addr = 48'h0; cycle(1);
    set_cfg(0, 0, 1, 1, 2'b00); sys_addr = 48'h40; cycle(1);
    hi_range_sel = 0;
    // R3: fine bit 6
    set_cfg(0, 1, 1, 1, 2'b00); sys_addr = 48'h40; cycle(1);
    sys_addr = 48'hFFFF_FFFF_FFBF; cycle(1);
    // R4: odd parity slice, bit 6 and bit 9 differ
    set_cfg(0, 0, 1, 0, 2'b10); sys_addr = 48'h1_0040; cycle(1);
    sys_addr = 48'h3_0040; cycle(1);
    set_cfg(0, 0, 1, 0, 2'b11); sys_addr = 48'h1_0040; cycle(1);
    sys_addr = 48'h1F_0200; cycle(1);
    // R5: several node bits set at once
    set_cfg(0, 0, 1, 0, 2'b01); sys_addr = 48'h8000; node_il_en = 3'b111; cycle(1);
    sys_addr = 48'h4000; node_il_en = 3'b011; cycle(1);
    sys_addr = 48'h2000; node_il_en = 3'b001; cycle(1);
    sys_addr = 48'h1000; node_il_en = 3'b000; cycle(1);
    sys_addr = 48'h7000; node_il_en = 3'b100; cycle(1);
    // R6 and R7
    set_cfg(0, 0, 0, 1, 2'b00); cycle(1);
    set_cfg(0, 1, 0, 1, 2'b00); cycle(1);
    set_cfg(0, 1, 0, 0, 2'b11); sys_addr = '1; cycle(1);
    // R8: idle cycles hold the channel, strobe stays low
    set_cfg(0, 0, 0, 1, 2'b00); cycle(1);
    set_cfg(0, 1, 0, 1, 2'b00); cycle(0); cycle(0);

    for (int i = 0; i < 3000; i++) begin
      sys_addr = {$urandom(), $urandom()};
      hi_range_sel = ($urandom() % 4) == 0;
      node_il_en = 3'($urandom());
      set_cfg(($urandom() % 5) == 0, 1'($urandom()), 1'($urandom()),
              1'($urandom()), 2'($urandom()));
      cycle(($urandom() % 4) != 0);
    end

    // R9: reset while a lookup is in flight
    set_cfg(0, 1, 0, 1, 2'b00);
    in_valid = 1; rst_n = 0;
    @(negedge clk);
    check(out_valid, 1'b0, "R9");
    check(out_chan, 1'b0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule